// File: doc/BRIEF.md
# Snooping MOESI Line Controller

This block manages coherence for one private cache on a shared snooping bus. The cache is direct-mapped, holds one data word per line, and tags every line with one of five states: Invalid, Shared, Exclusive, Owned or Modified. The processor side sends reads and writes and is stalled until each one finishes. A request that cannot finish locally becomes a single bus transaction, which waits for a grant from the external arbiter. A dirty victim is first written back with a flush transaction, and the miss request is issued after that.

In every cycle the controller also watches the transactions that other caches place on the bus. A line that is snooped and matches may change state. The controller can signal that it holds a copy, and it can put its own word on the bus in place of memory. Because the Owned state exists, a dirty line can be shared without first being written back. The cache holding it answers all later reads, while clean Shared holders stay silent. The bus encodes commands as 0 = read, 1 = read-for-ownership, 2 = upgrade and 3 = flush. This encoding applies to both the issued and the snooped command fields. The bus never grants this cache in a cycle that carries a snooped transaction.

Top module: `moesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, and `cpu_ready`, `bus_req`, `snp_shared` and `snp_supply` are all low. A first read to any address therefore issues a read (command 0).
- R2: When a read misses and `bus_shared_in` is low at the grant, the line is filled from `bus_rdata` and installed Exclusive. A later write to that line completes with no bus transaction, and a later snooped read of it is answered with shared high and supply low.
- R3: When a read misses and `bus_shared_in` is high at the grant, the line is filled from `bus_rdata` and installed Shared. A later write to it issues an upgrade (command 2).
- R4: A read that hits a valid line returns the stored word and issues no bus transaction. `cpu_ready` is high for exactly one cycle, two cycles after the cycle in which the request is accepted.
- R5: A write to an Invalid or mismatching line issues read-for-ownership (command 1). A write to a Shared or Owned line issues an upgrade (command 2). A write to a Modified or Exclusive line needs no bus transaction. In every case the line ends Modified and holds the written word.
- R6: A snooped read-for-ownership or upgrade whose address matches a valid line invalidates that line, so the next local access misses. A snooped address whose tag differs from the stored tag changes nothing.
- R7: A snooped read that hits a Modified line returns the line's word on `snp_data` with `snp_supply` and `snp_shared` high, and moves the line to Owned. No flush is issued.
- R8: An Owned line supplies its word on every snooped read and on a snooped read-for-ownership. A Shared line asserts shared on a snooped read but never asserts supply.
- R9: A snooped read that hits an Exclusive line asserts shared without supply and moves the line to Shared, so the next local write issues an upgrade.
- R10: A miss whose victim line is Modified or Owned first issues a flush (command 3). The flush carries the victim's address and word and is followed by the miss request. A victim in Exclusive or Shared is dropped with no flush.
- R11: In a cycle where `snp_valid` is high, no processor request is accepted and no local completion or granted transaction takes effect. A waiting request recomputes its command from the line state left by the snoop.
- R12: The snoop responses are registered. They appear in the cycle after the snooped transaction and are zero in every other cycle.
- R13: While `bus_req` is high and neither a grant nor a snoop arrives, `bus_req`, `bus_cmd` and `bus_addr` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Request address (low bits index the line) |
| cpu_wdata | input | DATA_W | Write word |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read result, valid with `cpu_ready` |
| bus_req | output | 1 | Transaction wanted on the bus |
| bus_cmd | output | 2 | Issued command (0 read, 1 read-for-ownership, 2 upgrade, 3 flush) |
| bus_addr | output | ADDR_W | Issued address (victim address for a flush) |
| bus_wdata | output | DATA_W | Write-back word for a flush, zero otherwise |
| bus_gnt | input | 1 | Grant; the transaction completes in this cycle |
| bus_rdata | input | DATA_W | Fill word from memory or from a supplying cache |
| bus_shared_in | input | 1 | Another cache holds the line, sampled with the grant |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as `bus_cmd` |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | This cache holds the snooped line |
| snp_supply | output | 1 | This cache drives the data for the snooped line |
| snp_data | output | DATA_W | Supplied word, zero when not supplying |

## Verification
An accepted request puts `bus_req` up in the very next cycle. A local completion or a granted final transaction raises `cpu_ready` in the cycle after that. A granted flush is followed one cycle later by the miss request. A snoop in cycle t is visible on the snoop outputs and in the line state during cycle t+1. The bench keeps a behavioural model that advances on the rising edge from the same inputs, drives stimulus at the falling edge, and compares every output against the model at the falling edge, so each result is sampled in the exact cycle it is due. Directed checks on returned words, command sequences and snoop replies name the requirement they cover.

// File: rtl/moesi_pkg.sv
package moesi_pkg;
  typedef enum logic [2:0] {
    LS_I = 3'd0, LS_S = 3'd1, LS_E = 3'd2, LS_O = 3'd3, LS_M = 3'd4
  } line_st_t;

  typedef enum logic [1:0] {
    BC_RD = 2'd0, BC_RDX = 2'd1, BC_UPGR = 2'd2, BC_FLUSH = 2'd3
  } bus_cmd_t;

  typedef enum logic [2:0] {
    PA_LOCAL, PA_RD, PA_RDX, PA_UPGR, PA_FLUSH
  } proc_act_t;

  typedef enum logic [1:0] {
    PH_IDLE, PH_BUSY, PH_DONE
  } phase_t;
endpackage

// File: rtl/moesi_line_store.sv
module moesi_line_store
  import moesi_pkg::*;
#(
  parameter int LINES  = 8,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  ra_idx,
  output line_st_t          ra_state,
  output logic [TAG_W-1:0]  ra_tag,
  output logic [DATA_W-1:0] ra_data,
  input  logic [IDX_W-1:0]  rb_idx,
  output line_st_t          rb_state,
  output logic [TAG_W-1:0]  rb_tag,
  output logic [DATA_W-1:0] rb_data,
  input  logic [IDX_W-1:0]  w_idx,
  input  logic              w_st_en,
  input  line_st_t          w_state,
  input  logic              w_tag_en,
  input  logic [TAG_W-1:0]  w_tag,
  input  logic              w_dat_en,
  input  logic [DATA_W-1:0] w_data
);
  line_st_t          st_q  [LINES];
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];

  // state bits need a reset; tag and word arrays stay reset-free for RAM mapping
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= LS_I;
    end else if (w_st_en) begin
      st_q[w_idx] <= w_state;
    end
  end

  always_ff @(posedge clk) begin
    if (w_tag_en) tag_q[w_idx] <= w_tag;
    if (w_dat_en) dat_q[w_idx] <= w_data;
  end

  assign ra_state = st_q[ra_idx];
  assign ra_tag   = tag_q[ra_idx];
  assign ra_data  = dat_q[ra_idx];
  assign rb_state = st_q[rb_idx];
  assign rb_tag   = tag_q[rb_idx];
  assign rb_data  = dat_q[rb_idx];
endmodule

// File: rtl/moesi_snoop_eval.sv
module moesi_snoop_eval
  import moesi_pkg::*;
(
  input  logic [1:0] cmd,
  input  line_st_t   cur,
  output line_st_t   nxt,
  output logic       shared,
  output logic       supply
);
  logic dirty;
  assign dirty = (cur == LS_M) || (cur == LS_O);

  always_comb begin
    nxt    = cur;
    shared = 1'b0;
    supply = 1'b0;
    case (cmd)
      BC_RD: begin
        shared = 1'b1;
        supply = dirty;
        nxt    = dirty ? LS_O : LS_S;
      end
      BC_RDX: begin
        supply = dirty;
        nxt    = LS_I;
      end
      BC_UPGR: nxt = LS_I;
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/moesi_proc_eval.sv
module moesi_proc_eval
  import moesi_pkg::*;
(
  input  logic      we,
  input  line_st_t  cur,
  input  logic      tag_match,
  output proc_act_t act
);
  logic valid;
  assign valid = (cur != LS_I);

  always_comb begin
    if (valid && !tag_match && (cur == LS_M || cur == LS_O))
      act = PA_FLUSH;
    else if (valid && tag_match) begin
      if (!we || cur == LS_M || cur == LS_E) act = PA_LOCAL;
      else                                   act = PA_UPGR;
    end else
      act = we ? PA_RDX : PA_RD;
  end
endmodule

// File: rtl/moesi_snoop_ctrl.sv
module moesi_snoop_ctrl
  import moesi_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LINES  = 8,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_shared_in,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared,
  output logic              snp_supply,
  output logic [DATA_W-1:0] snp_data
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  phase_t            ph_q;
  logic              p_we;
  logic [ADDR_W-1:0] p_addr;
  logic [DATA_W-1:0] p_wdata;
  logic [DATA_W-1:0] rd_q;
  logic              shr_q, sup_q;
  logic [DATA_W-1:0] sdat_q;

  logic [IDX_W-1:0]  s_idx, p_idx;
  logic [TAG_W-1:0]  s_tag, p_tag;
  line_st_t          sa_state, pb_state;
  logic [TAG_W-1:0]  sa_tag, pb_tag;
  logic [DATA_W-1:0] sa_data, pb_data;

  assign s_idx = snp_addr[IDX_W-1:0];
  assign s_tag = snp_addr[ADDR_W-1:IDX_W];
  assign p_idx = p_addr[IDX_W-1:0];
  assign p_tag = p_addr[ADDR_W-1:IDX_W];

  // snoop side
  line_st_t s_nxt;
  logic     s_shr, s_sup, s_hit;
  assign s_hit = snp_valid && (sa_state != LS_I) && (sa_tag == s_tag);

  moesi_snoop_eval snoop_eval_i (
    .cmd(snp_cmd), .cur(sa_state), .nxt(s_nxt), .shared(s_shr), .supply(s_sup)
  );

  // processor side
  proc_act_t act;
  logic      fire;
  moesi_proc_eval proc_eval_i (
    .we(p_we), .cur(pb_state), .tag_match(pb_tag == p_tag), .act(act)
  );
  assign fire = !snp_valid && (ph_q == PH_BUSY) && (act == PA_LOCAL || bus_gnt);

  // single write port: a snoop owns it, otherwise a firing request
  logic [IDX_W-1:0]  w_idx;
  logic              w_st_en, w_tag_en, w_dat_en;
  line_st_t          w_state;
  logic [DATA_W-1:0] w_data;

  always_comb begin
    w_idx    = p_idx;
    w_st_en  = 1'b0;
    w_tag_en = 1'b0;
    w_dat_en = 1'b0;
    w_state  = LS_M;
    w_data   = p_wdata;
    if (snp_valid) begin
      w_idx   = s_idx;
      w_st_en = s_hit;
      w_state = s_nxt;
    end else if (fire) begin
      case (act)
        PA_LOCAL: begin
          w_st_en  = p_we;
          w_dat_en = p_we;
        end
        PA_FLUSH: begin
          w_st_en = 1'b1;
          w_state = LS_I;
        end
        PA_RD: begin
          w_st_en  = 1'b1;
          w_tag_en = 1'b1;
          w_dat_en = 1'b1;
          w_state  = bus_shared_in ? LS_S : LS_E;
          w_data   = bus_rdata;
        end
        default: begin
          w_st_en  = 1'b1;
          w_tag_en = 1'b1;
          w_dat_en = 1'b1;
        end
      endcase
    end
  end

  moesi_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) store_i (
    .clk(clk), .rst(rst),
    .ra_idx(s_idx), .ra_state(sa_state), .ra_tag(sa_tag), .ra_data(sa_data),
    .rb_idx(p_idx), .rb_state(pb_state), .rb_tag(pb_tag), .rb_data(pb_data),
    .w_idx(w_idx), .w_st_en(w_st_en), .w_state(w_state),
    .w_tag_en(w_tag_en), .w_tag(p_tag), .w_dat_en(w_dat_en), .w_data(w_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q    <= PH_IDLE;
      p_we    <= 1'b0;
      p_addr  <= '0;
      p_wdata <= '0;
      rd_q    <= '0;
      shr_q   <= 1'b0;
      sup_q   <= 1'b0;
      sdat_q  <= '0;
    end else begin
      shr_q  <= s_hit && s_shr;
      sup_q  <= s_hit && s_sup;
      sdat_q <= (s_hit && s_sup) ? sa_data : '0;
      case (ph_q)
        PH_IDLE: if (cpu_req && !snp_valid) begin
          p_we    <= cpu_we;
          p_addr  <= cpu_addr;
          p_wdata <= cpu_wdata;
          ph_q    <= PH_BUSY;
        end
        PH_BUSY: if (fire && act != PA_FLUSH) begin
          ph_q <= PH_DONE;
          if (act == PA_LOCAL && !p_we) rd_q <= pb_data;
          if (act == PA_RD)             rd_q <= bus_rdata;
        end
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    case (act)
      PA_RDX:   bus_cmd = BC_RDX;
      PA_UPGR:  bus_cmd = BC_UPGR;
      PA_FLUSH: bus_cmd = BC_FLUSH;
      default:  bus_cmd = BC_RD;
    endcase
  end

  assign bus_req    = (ph_q == PH_BUSY) && (act != PA_LOCAL);
  assign bus_addr   = (act == PA_FLUSH) ? {pb_tag, p_idx} : p_addr;
  assign bus_wdata  = (act == PA_FLUSH) ? pb_data : '0;
  assign cpu_ready  = (ph_q == PH_DONE);
  assign cpu_rdata  = rd_q;
  assign snp_shared = shr_q;
  assign snp_supply = sup_q;
  assign snp_data   = sdat_q;
endmodule

// File: rtl/moesi_snoop_ctrl_chk.sv
module moesi_snoop_ctrl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_ready,
  input logic              bus_req,
  input logic [1:0]        bus_cmd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_gnt,
  input logic              snp_valid,
  input logic [1:0]        snp_cmd,
  input logic              snp_shared,
  input logic              snp_supply
);
  assert_ready_pulse_R4: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);

  assert_ready_no_req_R4: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |-> !bus_req);

  assert_supply_source_R8: assert property (@(posedge clk) disable iff (rst)
    snp_supply |-> ($past(snp_valid) && ($past(snp_cmd) == 2'd0 || $past(snp_cmd) == 2'd1)));

  assert_shared_source_R12: assert property (@(posedge clk) disable iff (rst)
    snp_shared |-> ($past(snp_valid) && $past(snp_cmd) == 2'd0));

  assert_snoop_blocks_R11: assert property (@(posedge clk) disable iff (rst)
    (snp_valid && !bus_req && !cpu_ready) |=> !cpu_ready);

  assert_req_hold_R13: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_gnt && !snp_valid) |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr)));
endmodule

bind moesi_snoop_ctrl moesi_snoop_ctrl_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst(rst), .cpu_ready(cpu_ready), .bus_req(bus_req),
  .bus_cmd(bus_cmd), .bus_addr(bus_addr), .bus_gnt(bus_gnt),
  .snp_valid(snp_valid), .snp_cmd(snp_cmd),
  .snp_shared(snp_shared), .snp_supply(snp_supply)
);

// File: tb/moesi_snoop_ctrl_tb_top.sv
module moesi_snoop_ctrl_tb_top;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NL = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic          cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = 0;
  logic [DW-1:0] cpu_wdata = 0;
  logic          cpu_ready;
  logic [DW-1:0] cpu_rdata;
  logic          bus_req;
  logic [1:0]    bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          bus_gnt = 0, bus_shared_in = 0;
  logic [DW-1:0] bus_rdata = 0;
  logic          snp_valid = 0;
  logic [1:0]    snp_cmd = 0;
  logic [AW-1:0] snp_addr = 0;
  logic          snp_shared, snp_supply;
  logic [DW-1:0] snp_data;

  moesi_snoop_ctrl #(.ADDR_W(AW), .LINES(NL), .DATA_W(DW)) dut_i (.*);

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // behavioural reference: states 0=I 1=S 2=E 3=O 4=M ; phase 0 idle 1 busy 2 done
  int            m_st [NL];
  logic [4:0]    m_tag[NL];
  logic [DW-1:0] m_dat[NL];
  int            m_ph;
  logic          m_we;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_wd, m_rd;
  logic          e_shr, e_sup;
  logic [DW-1:0] e_sdat;

  // action codes: 0 local, 1 read, 2 read-own, 3 upgrade, 4 flush
  function automatic int m_act();
    int i;
    i = int'(m_addr[2:0]);
    if (m_st[i] != 0 && m_tag[i] != m_addr[7:3] && m_st[i] >= 3) return 4;
    if (m_st[i] != 0 && m_tag[i] == m_addr[7:3]) begin
      if (!m_we || m_st[i] == 4 || m_st[i] == 2) return 0;
      return 3;
    end
    return m_we ? 2 : 1;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NL; i++) begin m_st[i] = 0; m_tag[i] = 0; m_dat[i] = 0; end
      m_ph = 0; m_we = 0; m_addr = 0; m_wd = 0; m_rd = 0;
      e_shr = 0; e_sup = 0; e_sdat = 0;
    end else begin
      int a, si, pi;
      a = m_act();
      e_shr = 0; e_sup = 0; e_sdat = 0;
      if (snp_valid) begin
        si = int'(snp_addr[2:0]);
        if (m_st[si] != 0 && m_tag[si] == snp_addr[7:3]) begin
          if (snp_cmd == 2'd0) begin
            e_shr = 1;
            if (m_st[si] >= 3) begin e_sup = 1; e_sdat = m_dat[si]; m_st[si] = 3; end
            else m_st[si] = 1;
          end else if (snp_cmd == 2'd1) begin
            if (m_st[si] >= 3) begin e_sup = 1; e_sdat = m_dat[si]; end
            m_st[si] = 0;
          end else if (snp_cmd == 2'd2) m_st[si] = 0;
        end
      end
      pi = int'(m_addr[2:0]);
      if (m_ph == 0) begin
        if (cpu_req && !snp_valid) begin
          m_we = cpu_we; m_addr = cpu_addr; m_wd = cpu_wdata; m_ph = 1;
        end
      end else if (m_ph == 1) begin
        if (!snp_valid && (a == 0 || bus_gnt)) begin
          if (a == 0) begin
            if (m_we) begin m_st[pi] = 4; m_dat[pi] = m_wd; end
            else m_rd = m_dat[pi];
            m_ph = 2;
          end else if (a == 4) m_st[pi] = 0;
          else if (a == 1) begin
            m_st[pi] = bus_shared_in ? 1 : 2; m_tag[pi] = m_addr[7:3];
            m_dat[pi] = bus_rdata; m_rd = bus_rdata; m_ph = 2;
          end else begin
            m_st[pi] = 4; m_tag[pi] = m_addr[7:3]; m_dat[pi] = m_wd; m_ph = 2;
          end
        end
      end else m_ph = 0;
    end
  end

  // every-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      int a;
      logic er;
      a  = m_act();
      er = (m_ph == 1) && (a != 0);
      chk(bus_req === er, cur_req, "bus_req", 32'(bus_req), 32'(er));
      if (er) begin
        chk(bus_cmd === 2'(a - 1), cur_req, "bus_cmd", 32'(bus_cmd), 32'(a - 1));
        chk(bus_addr === ((a == 4) ? {m_tag[m_addr[2:0]], m_addr[2:0]} : m_addr),
            cur_req, "bus_addr", 32'(bus_addr), 32'(m_addr));
        chk(bus_wdata === ((a == 4) ? m_dat[m_addr[2:0]] : 16'h0),
            cur_req, "bus_wdata", 32'(bus_wdata), 32'(m_dat[m_addr[2:0]]));
      end
      chk(cpu_ready === (m_ph == 2), cur_req, "cpu_ready", 32'(cpu_ready), 32'(m_ph == 2));
      if (m_ph == 2) chk(cpu_rdata === m_rd, cur_req, "cpu_rdata", 32'(cpu_rdata), 32'(m_rd));
      chk(snp_shared === e_shr, "R12", "snp_shared", 32'(snp_shared), 32'(e_shr));
      chk(snp_supply === e_sup, "R12", "snp_supply", 32'(snp_supply), 32'(e_sup));
      chk(snp_data === e_sdat, "R12", "snp_data", 32'(snp_data), 32'(e_sdat));
    end
  end

  // transaction log filled by cpu_op
  int            log_n;
  logic [1:0]    log_c[4];
  logic [AW-1:0] log_a0;
  logic [DW-1:0] log_d0;
  logic [DW-1:0] got_rd;

  task automatic cpu_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        input logic sh, input logic [DW-1:0] fill);
    int guard;
    log_n = 0; got_rd = 0; log_a0 = 0; log_d0 = 0;
    for (int k = 0; k < 4; k++) log_c[k] = 0;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    guard = 0;
    forever begin
      @(negedge clk);
      bus_gnt = 0;
      if (cpu_ready) begin got_rd = cpu_rdata; cpu_req = 0; break; end
      if (bus_req) begin
        if (log_n == 0) begin log_a0 = bus_addr; log_d0 = bus_wdata; end
        if (log_n < 4) log_c[log_n] = bus_cmd;
        log_n++;
        bus_gnt = 1; bus_rdata = fill; bus_shared_in = sh;
      end
      guard++;
      if (guard > 40) begin
        chk(0, cur_req, "request never completed", 0, 1);
        cpu_req = 0; break;
      end
    end
  endtask

  logic          o_shr, o_sup;
  logic [DW-1:0] o_dat;
  task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a);
    @(negedge clk);
    snp_valid = 1; snp_cmd = c; snp_addr = a;
    @(negedge clk);
    snp_valid = 0;
    o_shr = snp_shared; o_sup = snp_supply; o_dat = snp_data;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "all", "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 0;
    @(negedge clk);
    cur_req = "R1";
    chk(!cpu_ready && !bus_req && !snp_shared && !snp_supply, "R1", "outputs after reset",
        {cpu_ready, bus_req, snp_shared, snp_supply}, 0);

    // R1/R2: first read misses, fills Exclusive
    cur_req = "R2";
    cpu_op(0, 8'h01, 0, 0, 16'h1111);
    chk(log_n == 1 && log_c[0] == 2'd0, "R1", "first read issues read", log_n, 1);
    chk(got_rd == 16'h1111, "R2", "fill word", got_rd, 16'h1111);
    cpu_op(1, 8'h01, 16'hA5A5, 0, 0);
    chk(log_n == 0, "R2", "write to Exclusive is silent", log_n, 0);
    cur_req = "R4";
    cpu_op(0, 8'h01, 0, 0, 0);
    chk(log_n == 0 && got_rd == 16'hA5A5, "R4", "read hit", got_rd, 16'hA5A5);

    // R7/R8: Modified supplies, becomes Owned, keeps supplying
    cur_req = "R7";
    snoop(2'd0, 8'h01);
    chk(o_sup && o_shr && o_dat == 16'hA5A5, "R7", "supply from Modified", o_dat, 16'hA5A5);
    snoop(2'd0, 8'h01);
    chk(o_sup && o_dat == 16'hA5A5, "R8", "Owned supplies again", o_dat, 16'hA5A5);
    cur_req = "R5";
    cpu_op(1, 8'h01, 16'hBEEF, 0, 0);
    chk(log_n == 1 && log_c[0] == 2'd2, "R5", "write on Owned upgrades", log_c[0], 2);

    // R3/R8: shared fill, silent Shared holder
    cur_req = "R3";
    cpu_op(0, 8'h02, 0, 1, 16'h2222);
    chk(got_rd == 16'h2222, "R3", "shared fill word", got_rd, 16'h2222);
    snoop(2'd0, 8'h02);
    chk(o_shr && !o_sup, "R8", "Shared holder never supplies", o_sup, 0);
    cpu_op(1, 8'h02, 16'h2A2A, 0, 0);
    chk(log_n == 1 && log_c[0] == 2'd2, "R3", "write on Shared upgrades", log_c[0], 2);

    // R9: Exclusive demoted by snooped read
    cur_req = "R9";
    cpu_op(0, 8'h03, 0, 0, 16'h3333);
    snoop(2'd0, 8'h03);
    chk(o_shr && !o_sup, "R9", "Exclusive answers shared only", {o_shr, o_sup}, 2);
    cpu_op(1, 8'h03, 16'h3B3B, 0, 0);
    chk(log_n == 1 && log_c[0] == 2'd2, "R9", "after demotion write upgrades", log_c[0], 2);

    // R6: invalidation, tag mismatch ignored
    cur_req = "R6";
    snoop(2'd1, 8'h02);
    chk(o_sup && o_dat == 16'h2A2A, "R6", "Modified supplies on read-own", o_dat, 16'h2A2A);
    cpu_op(0, 8'h02, 0, 0, 16'h2C2C);
    chk(log_n == 1 && log_c[0] == 2'd0 && got_rd == 16'h2C2C, "R6", "refetch after read-own", got_rd, 16'h2C2C);
    cpu_op(0, 8'h04, 0, 1, 16'h4444);
    snoop(2'd2, 8'h04);
    chk(!o_shr && !o_sup, "R6", "upgrade snoop silent", {o_shr, o_sup}, 0);
    cpu_op(0, 8'h04, 0, 0, 16'h4545);
    chk(log_n == 1 && log_c[0] == 2'd0, "R6", "refetch after upgrade snoop", log_n, 1);
    snoop(2'd1, 8'h0B);
    chk(!o_shr && !o_sup, "R6", "mismatching tag ignored", {o_shr, o_sup}, 0);
    cpu_op(0, 8'h03, 0, 0, 0);
    chk(log_n == 0 && got_rd == 16'h3B3B, "R6", "line kept after mismatch", got_rd, 16'h3B3B);
    cur_req = "R5";
    cpu_op(1, 8'h07, 16'h7777, 0, 0);
    chk(log_n == 1 && log_c[0] == 2'd1, "R5", "write miss read-own", log_c[0], 1);

    // R10: dirty eviction then clean eviction
    cur_req = "R10";
    cpu_op(0, 8'h09, 0, 0, 16'h9999);
    chk(log_n == 2 && log_c[0] == 2'd3 && log_c[1] == 2'd0, "R10", "flush then read", log_n, 2);
    chk(log_a0 == 8'h01 && log_d0 == 16'hBEEF, "R10", "flush victim word", log_d0, 16'hBEEF);
    cpu_op(0, 8'h11, 0, 0, 16'h1212);
    chk(log_n == 1 && log_c[0] == 2'd0, "R10", "clean victim dropped", log_n, 1);

    // R11/R13: snoop priority and re-evaluation
    cur_req = "R11";
    cpu_op(0, 8'h05, 0, 1, 16'h5050);
    @(negedge clk);
    cpu_req = 1; cpu_we = 1; cpu_addr = 8'h05; cpu_wdata = 16'h5555;
    snp_valid = 1; snp_cmd = 2'd0; snp_addr = 8'h06;
    @(negedge clk);
    snp_valid = 0;
    chk(!bus_req, "R11", "not accepted during snoop", bus_req, 0);
    @(negedge clk);
    chk(bus_req && bus_cmd == 2'd2, "R11", "pending upgrade", bus_cmd, 2);
    snp_valid = 1; snp_cmd = 2'd2; snp_addr = 8'h05;
    bus_gnt = 1; bus_rdata = 16'hDEAD; bus_shared_in = 0;
    @(negedge clk);
    snp_valid = 0; bus_gnt = 0;
    chk(bus_req && bus_cmd == 2'd1, "R11", "recomputed to read-own", bus_cmd, 1);
    cur_req = "R13";
    repeat (2) begin
      @(negedge clk);
      chk(bus_req && bus_cmd == 2'd1 && bus_addr == 8'h05, "R13", "request held", bus_cmd, 1);
    end
    bus_gnt = 1;
    @(negedge clk);
    bus_gnt = 0;
    chk(cpu_ready, "R11", "completes after grant", cpu_ready, 1);
    cpu_req = 0;
    cur_req = "R4";
    cpu_op(0, 8'h05, 0, 0, 0);
    chk(log_n == 0 && got_rd == 16'h5555, "R4", "written word after re-evaluation", got_rd, 16'h5555);

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule